// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block is the bus-facing half of a controller for a single open-drain data line shared by a master and any number of addressable sensor slaves. It turns one-word requests into the microsecond-accurate waveforms such a bus expects. The request can be a bus reset with a presence check, a single bit written or read, or a whole byte written or read least significant bit first. All timing is derived from the system clock through a parameter giving the number of clock cycles per microsecond.

A byte write can also arm a strong-pullup handoff. When the last slot of the byte has finished, the engine releases the line, raises a separate enable for an external low-impedance pull-up transistor, and keeps it raised for a programmed number of microseconds. This supplies a slave that draws its power from the bus while it converts a temperature or writes its nonvolatile memory. The engine stays busy for that whole time, so no other traffic can reach the line.

The surrounding controller sequences the commands: addressing, search and the rest. It issues one request whenever `busy` is low and collects the result on `done`.

Top module: `owm_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `presence`, `spu_en` and `line_drive_low` are 0 and `rx_byte` is 0x00.
- R2: A request is taken when `cmd_valid` is high and `busy` is low, and `busy` rises on the next cycle. The operation codes are 0 bus reset, 1 write bit, 2 read bit, 3 write byte and 4 read byte. Codes 5 to 7 are ignored, and so is any `cmd_valid` seen while `busy` is high.
- R3: A bus reset drives the line low for exactly 480 µs, then releases it for 480 µs before completing. The line is never held low longer than 480 µs at a time.
- R4: During a bus reset, `presence` is set only if the synchronised line reads low on a microsecond sample taken from 60 µs up to 240 µs after the release. A low pulse that ends before 60 µs yields 0.
- R5: Every bit slot lasts 72 µs, with the line released for at least the last 2 µs. A 1 is written as a 6 µs low pulse and a 0 as a 64 µs low pulse. Write-bit sends `tx_byte[0]`.
- R6: A read slot drives the line low for 2 µs and samples it at the end of the 14th microsecond. A read-bit request returns the bit in `rx_byte[0]`, with `rx_byte[7:1]` = 0.
- R7: A write-byte request sends `tx_byte` as 8 slots, bit 0 first.
- R8: A read-byte request performs 8 read slots. The first bit received lands in `rx_byte[0]` and the last in `rx_byte[7]`.
- R9: A write-byte request with `cmd_spu` = 1 and `spu_us` ≠ 0 raises `spu_en` on the cycle after its last slot. `spu_en` stays high for exactly `spu_us` µs while the line is left undriven and `busy` stays high. `done` follows. With `spu_us` = 0, `spu_en` never rises.
- R10: `done` is a one-cycle pulse on the same cycle that `busy` falls. `presence` changes only when a bus reset completes and `rx_byte` only when a read completes; otherwise both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_spu | input | 1 | Arm strong pullup after a byte write |
| spu_us | input | SPU_W | Strong-pullup hold time in µs |
| tx_byte | input | 8 | Data to write |
| rx_byte | output | 8 | Data read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last bus reset |
| line_in | input | 1 | Sensed level of the bus line |
| line_drive_low | output | 1 | 1 = pull the bus line low |
| spu_en | output | 1 | Strong-pullup transistor enable |

## Verification
Two events can land on the same clock cycle. The first is a fresh request strobe arriving while a byte read is partway through its slots. The bench provokes this by pulsing a bus-reset request in the middle of a read byte. It then judges the outcome by the low-pulse widths on the line, which must all remain 2 µs read pulses, and by a read result that arrives correctly with no extra completion. The second is the completion of the last write slot coinciding with the strong-pullup handoff. The bench measures the `spu_en` pulse length in cycles, confirms that no low pulse appears during it, and checks that the busy time covers both the slots and the hold.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int UCNT_W = 10;
    typedef logic [UCNT_W-1:0] ucnt_t;

    // microsecond marks inside one operation, counted from its falling edge
    localparam ucnt_t T_RST_LOW   = ucnt_t'(480);
    localparam ucnt_t T_RST_END   = ucnt_t'(960);
    localparam ucnt_t T_PRES_FROM = ucnt_t'(540);
    localparam ucnt_t T_PRES_TO   = ucnt_t'(720);
    localparam ucnt_t T_W1_LOW    = ucnt_t'(6);
    localparam ucnt_t T_W0_LOW    = ucnt_t'(64);
    localparam ucnt_t T_RD_LOW    = ucnt_t'(2);
    localparam ucnt_t T_RD_SAMPLE = ucnt_t'(13);
    localparam ucnt_t T_SLOT_END  = ucnt_t'(72);

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } owm_op_e;

    typedef enum logic [1:0] {
        SLOT_RST,
        SLOT_W0,
        SLOT_W1,
        SLOT_RD
    } slot_kind_e;

    typedef struct packed {
        logic bit_val;
        logic presence;
    } slot_res_t;

    function automatic logic op_is_valid(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

    function automatic logic op_is_byte(input owm_op_e op);
        return (op == OP_WBYTE) || (op == OP_RBYTE);
    endfunction

    function automatic slot_kind_e kind_for(input owm_op_e op, input logic b);
        case (op)
            OP_RESET:          return SLOT_RST;
            OP_RBIT, OP_RBYTE: return SLOT_RD;
            default:           return b ? SLOT_W1 : SLOT_W0;
        endcase
    endfunction

    function automatic ucnt_t low_len(input slot_kind_e k);
        case (k)
            SLOT_RST: return T_RST_LOW;
            SLOT_W0:  return T_W0_LOW;
            SLOT_W1:  return T_W1_LOW;
            default:  return T_RD_LOW;
        endcase
    endfunction

    function automatic ucnt_t end_len(input slot_kind_e k);
        return (k == SLOT_RST) ? T_RST_END : T_SLOT_END;
    endfunction

endpackage

// File: rtl/owm_usec_tick.sv
module owm_usec_tick #(
    parameter int CLKS_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owm_slot.sv
module owm_slot
    import owm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  slot_kind_e kind,
    input  logic       us_tick,
    input  logic       line_in,
    output logic       active,
    output logic       drive_low,
    output logic       done,
    output slot_res_t  res
);
    ucnt_t      t;
    slot_kind_e kind_q;

    assign drive_low = active && (t < low_len(kind_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            t      <= '0;
            kind_q <= SLOT_RST;
            done   <= 1'b0;
            res    <= '0;
        end else begin
            done <= 1'b0;
            if (!active && start) begin
                active <= 1'b1;
                t      <= '0;
                kind_q <= kind;
                res    <= '0;
            end else if (active && us_tick) begin
                if (kind_q == SLOT_RST && t >= T_PRES_FROM && t < T_PRES_TO && !line_in)
                    res.presence <= 1'b1;
                if (kind_q == SLOT_RD && t == T_RD_SAMPLE)
                    res.bit_val <= line_in;
                if (t == end_len(kind_q) - ucnt_t'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    t <= t + ucnt_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/owm_seq.sv
module owm_seq
    import owm_pkg::*;
#(
    parameter int SPU_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_spu,
    input  logic [SPU_W-1:0] spu_us,
    input  logic [7:0]       tx_byte,
    input  logic             slot_done,
    input  slot_res_t        slot_res,
    input  logic             us_tick,
    output logic             slot_start,
    output slot_kind_e       slot_kind,
    output logic             busy,
    output logic             done,
    output logic             presence,
    output logic             spu_en,
    output logic [7:0]       rx_byte
);
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_SLOT, SEQ_SPU} seq_e;
    localparam logic [SPU_W-1:0] ONE = SPU_W'(1);

    seq_e             state;
    owm_op_e          op_q;
    logic [7:0]       sh;
    logic [7:0]       rx_sh;
    logic [2:0]       bitcnt;
    logic             spu_arm;
    logic [SPU_W-1:0] spu_len;
    logic [SPU_W-1:0] spu_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            op_q       <= OP_RESET;
            sh         <= '0;
            rx_sh      <= '0;
            bitcnt     <= '0;
            spu_arm    <= 1'b0;
            spu_len    <= '0;
            spu_cnt    <= '0;
            slot_start <= 1'b0;
            slot_kind  <= SLOT_RST;
            busy       <= 1'b0;
            done       <= 1'b0;
            presence   <= 1'b0;
            spu_en     <= 1'b0;
            rx_byte    <= '0;
        end else begin
            slot_start <= 1'b0;
            done       <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (cmd_valid && op_is_valid(cmd_op)) begin
                        op_q       <= owm_op_e'(cmd_op);
                        busy       <= 1'b1;
                        sh         <= tx_byte;
                        bitcnt     <= '0;
                        slot_start <= 1'b1;
                        slot_kind  <= kind_for(owm_op_e'(cmd_op), tx_byte[0]);
                        spu_arm    <= cmd_spu && (cmd_op == OP_WBYTE) && (spu_us != '0);
                        spu_len    <= spu_us;
                        state      <= SEQ_SLOT;
                    end
                end
                SEQ_SLOT: begin
                    if (slot_done) begin
                        rx_sh <= {slot_res.bit_val, rx_sh[7:1]};
                        if (op_is_byte(op_q) && bitcnt != 3'd7) begin
                            bitcnt     <= bitcnt + 3'd1;
                            sh         <= {1'b0, sh[7:1]};
                            slot_start <= 1'b1;
                            slot_kind  <= kind_for(op_q, sh[1]);
                        end else if (spu_arm) begin
                            state   <= SEQ_SPU;
                            spu_en  <= 1'b1;
                            spu_cnt <= '0;
                        end else begin
                            state <= SEQ_IDLE;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            case (op_q)
                                OP_RESET: presence <= slot_res.presence;
                                OP_RBIT:  rx_byte  <= {7'b0, slot_res.bit_val};
                                OP_RBYTE: rx_byte  <= {slot_res.bit_val, rx_sh[7:1]};
                                default:  ;
                            endcase
                        end
                    end
                end
                SEQ_SPU: begin
                    if (us_tick) begin
                        if (spu_cnt == spu_len - ONE) begin
                            spu_en <= 1'b0;
                            busy   <= 1'b0;
                            done   <= 1'b1;
                            state  <= SEQ_IDLE;
                        end else begin
                            spu_cnt <= spu_cnt + ONE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/owm_engine.sv
module owm_engine
    import owm_pkg::*;
#(
    parameter int CLKS_PER_US = 50,
    parameter int SPU_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_spu,
    input  logic [SPU_W-1:0] spu_us,
    input  logic [7:0]       tx_byte,
    output logic [7:0]       rx_byte,
    output logic             busy,
    output logic             done,
    output logic             presence,
    input  logic             line_in,
    output logic             line_drive_low,
    output logic             spu_en
);
    logic [1:0] sync_q;
    logic       line_s;
    logic       us_tick;
    logic       slot_active;
    logic       slot_start;
    logic       slot_done;
    slot_kind_e slot_kind;
    slot_res_t  slot_res;

    // two-stage synchroniser for the asynchronous bus level
    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], line_in};
    end
    assign line_s = sync_q[1];

    owm_usec_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (slot_active | spu_en),
        .tick (us_tick)
    );

    owm_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .start     (slot_start),
        .kind      (slot_kind),
        .us_tick   (us_tick),
        .line_in   (line_s),
        .active    (slot_active),
        .drive_low (line_drive_low),
        .done      (slot_done),
        .res       (slot_res)
    );

    owm_seq #(.SPU_W(SPU_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_spu    (cmd_spu),
        .spu_us     (spu_us),
        .tx_byte    (tx_byte),
        .slot_done  (slot_done),
        .slot_res   (slot_res),
        .us_tick    (us_tick),
        .slot_start (slot_start),
        .slot_kind  (slot_kind),
        .busy       (busy),
        .done       (done),
        .presence   (presence),
        .spu_en     (spu_en),
        .rx_byte    (rx_byte)
    );
endmodule

// File: rtl/owm_engine_chk.sv
module owm_engine_chk #(
    parameter int CLKS_PER_US = 50
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       line_drive_low,
    input logic       spu_en
);
    localparam int LOW_LIMIT = 480 * CLKS_PER_US;

    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 low_cnt <= 0;
        else if (line_drive_low) low_cnt <= low_cnt + 1;
        else                     low_cnt <= 0;
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_drive_low);

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op <= 3'd4) |=> busy);

    a_r2_bad_op: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op > 3'd4) |=> !busy);

    a_r3_low_limit: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LOW_LIMIT);

    a_r9_spu_released: assert property (@(posedge clk) disable iff (rst)
        spu_en |-> !line_drive_low);

    a_r9_spu_busy: assert property (@(posedge clk) disable iff (rst)
        spu_en |-> busy);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_busy_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind owm_engine owm_engine_chk #(.CLKS_PER_US(CLKS_PER_US)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .busy           (busy),
    .done           (done),
    .line_drive_low (line_drive_low),
    .spu_en         (spu_en)
);

// File: tb/owm_engine_bench.sv
`timescale 1ns/1ps
module owm_engine_bench;
    localparam int C     = 4;
    localparam int SPU_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic             cmd_spu = 1'b0;
    logic [SPU_W-1:0] spu_us = '0;
    logic [7:0]       tx_byte = '0;
    logic [7:0]       rx_byte;
    logic             busy, done, presence, drv, spu_en;
    logic             slave_low = 1'b0;
    logic             bus;

    assign bus = !(drv | slave_low);

    always #2.5 clk = ~clk;

    owm_engine #(.CLKS_PER_US(C), .SPU_W(SPU_W)) u_owm_engine (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_spu        (cmd_spu),
        .spu_us         (spu_us),
        .tx_byte        (tx_byte),
        .rx_byte        (rx_byte),
        .busy           (busy),
        .done           (done),
        .presence       (presence),
        .line_in        (bus),
        .line_drive_low (drv),
        .spu_en         (spu_en)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard items and measured waveforms
    typedef struct {
        logic [7:0] rx;
        logic       pres;
        string      req;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;
    int   ew_q[$];
    int   w_q[$];
    int   spu_q[$];
    int   run_w = 0;
    int   run_s = 0;

    // slave model controls
    bit   rd_en = 1'b0;
    logic [7:0] rd_data = '0;
    int   rd_idx = 0;
    bit   pres_en = 1'b0;
    int   pres_start = 0;
    int   pres_len = 0;

    initial forever begin
        @(posedge drv);
        if (rd_en) begin
            slave_low = !rd_data[rd_idx];
            rd_idx++;
            repeat (30 * C) @(posedge clk);
            slave_low = 1'b0;
        end else if (pres_en) begin
            @(negedge drv);
            repeat (pres_start * C) @(posedge clk);
            slave_low = 1'b1;
            repeat (pres_len * C) @(posedge clk);
            slave_low = 1'b0;
        end
    end

    // monitor: pulse widths, strong-pullup length, results at done
    always @(negedge clk) begin
        if (drv) run_w++;
        else if (run_w != 0) begin w_q.push_back(run_w); run_w = 0; end
        if (spu_en) run_s++;
        else if (run_s != 0) begin spu_q.push_back(run_s); run_s = 0; end
        if (done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                cur = exp_q.pop_front();
                check(rx_byte == cur.rx, cur.req, "rx_byte", rx_byte, cur.rx);
                check(presence == cur.pres, cur.req, "presence", presence, cur.pres);
                check(!busy, "R10", "busy at done", busy, 0);
            end
        end
    end

    logic [7:0] hold_rx = '0;
    logic       hold_pres = 1'b0;

    task automatic push_exp(input logic [7:0] rx, input logic pres, input string req);
        exp_t e;
        e.rx = rx; e.pres = pres; e.req = req;
        exp_q.push_back(e);
        hold_rx = rx;
        hold_pres = pres;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] tx, input bit spu,
                          input int sus, input int lo, input int hi, input int poke,
                          input string req);
        int n = 0;
        @(negedge clk);
        cmd_op = op; tx_byte = tx; cmd_spu = spu; spu_us = SPU_W'(sus);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && n < 20000) begin
            if (busy) n++;
            if (poke > 0 && n == poke) begin cmd_valid = 1'b1; cmd_op = 3'd0; end
            else cmd_valid = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(n >= lo && n <= hi, req, "busy cycles", n, lo);
        repeat (3) @(negedge clk);
        check(w_q.size() == ew_q.size(), req, "low pulse count", w_q.size(), ew_q.size());
        while (ew_q.size() != 0 && w_q.size() != 0) begin
            int a = w_q.pop_front();
            int e = ew_q.pop_front();
            check(a == e, req, "low pulse width", a, e);
        end
        w_q.delete();
        ew_q.delete();
    endtask

    localparam int BYTE_LO = 8 * 72 * C;
    localparam int BYTE_HI = 8 * 72 * C + 24;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy, "R1", "busy", busy, 0);
        check(!done, "R1", "done", done, 0);
        check(!presence, "R1", "presence", presence, 0);
        check(!spu_en, "R1", "spu_en", spu_en, 0);
        check(!drv, "R1", "line_drive_low", drv, 0);
        check(rx_byte == 8'h00, "R1", "rx_byte", rx_byte, 0);

        // R3 R4 bus reset with a presence pulse inside the window
        pres_en = 1'b1; pres_start = 30; pres_len = 120;
        ew_q.push_back(480 * C);
        push_exp(8'h00, 1'b1, "R4");
        run_op(3'd0, 8'h00, 1'b0, 0, 960 * C, 960 * C + 3, 0, "R3");

        // R4 no slave answers
        pres_en = 1'b0;
        ew_q.push_back(480 * C);
        push_exp(8'h00, 1'b0, "R4");
        run_op(3'd0, 8'h00, 1'b0, 0, 960 * C, 960 * C + 3, 0, "R3");

        // R4 boundary: pulse ends before 60 us
        pres_en = 1'b1; pres_start = 15; pres_len = 35;
        ew_q.push_back(480 * C);
        push_exp(8'h00, 1'b0, "R4");
        run_op(3'd0, 8'h00, 1'b0, 0, 960 * C, 960 * C + 3, 0, "R4");

        // presence back to 1 for hold checks later
        pres_start = 30; pres_len = 120;
        ew_q.push_back(480 * C);
        push_exp(8'h00, 1'b1, "R4");
        run_op(3'd0, 8'h00, 1'b0, 0, 960 * C, 960 * C + 3, 0, "R4");
        pres_en = 1'b0;

        // R5 single bits, results held (R10)
        ew_q.push_back(6 * C);
        push_exp(hold_rx, hold_pres, "R10");
        run_op(3'd1, 8'hFF, 1'b0, 0, 72 * C, 72 * C + 3, 0, "R5");
        ew_q.push_back(64 * C);
        push_exp(hold_rx, hold_pres, "R10");
        run_op(3'd1, 8'hFE, 1'b0, 0, 72 * C, 72 * C + 3, 0, "R5");

        // R7 byte write, LSB first: A5 -> 1,0,1,0,0,1,0,1
        for (int i = 0; i < 8; i++) ew_q.push_back(((8'hA5 >> i) & 1) != 0 ? 6 * C : 64 * C);
        push_exp(hold_rx, hold_pres, "R7");
        run_op(3'd3, 8'hA5, 1'b0, 0, BYTE_LO, BYTE_HI, 0, "R7");

        // R6 read bit 0 then 1
        rd_en = 1'b1; rd_idx = 0; rd_data = 8'h00;
        ew_q.push_back(2 * C);
        push_exp(8'h00, hold_pres, "R6");
        run_op(3'd2, 8'h00, 1'b0, 0, 72 * C, 72 * C + 3, 0, "R6");
        rd_idx = 0; rd_data = 8'hFF;
        ew_q.push_back(2 * C);
        push_exp(8'h01, hold_pres, "R6");
        run_op(3'd2, 8'h00, 1'b0, 0, 72 * C, 72 * C + 3, 0, "R6");

        // R8 read byte
        rd_idx = 0; rd_data = 8'h3C;
        for (int i = 0; i < 8; i++) ew_q.push_back(2 * C);
        push_exp(8'h3C, hold_pres, "R8");
        run_op(3'd4, 8'h00, 1'b0, 0, BYTE_LO, BYTE_HI, 0, "R8");

        // R2 request strobe during a byte read is ignored
        rd_idx = 0; rd_data = 8'hC9;
        for (int i = 0; i < 8; i++) ew_q.push_back(2 * C);
        push_exp(8'hC9, hold_pres, "R2");
        run_op(3'd4, 8'h00, 1'b0, 0, BYTE_LO, BYTE_HI, 100 * C, "R2");
        rd_en = 1'b0;

        // R2 unused operation code is ignored
        @(negedge clk);
        cmd_op = 3'd6; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(!busy && !drv, "R2", "bad op started work", busy, 0);
            @(negedge clk);
        end

        // R9 strong pullup after a byte write
        for (int i = 0; i < 8; i++) ew_q.push_back(((8'h0F >> i) & 1) != 0 ? 6 * C : 64 * C);
        push_exp(hold_rx, hold_pres, "R9");
        run_op(3'd3, 8'h0F, 1'b1, 20, BYTE_LO + 20 * C, BYTE_HI + 20 * C, 0, "R9");
        check(spu_q.size() == 1, "R9", "spu pulse count", spu_q.size(), 1);
        if (spu_q.size() == 1) check(spu_q[0] == 20 * C, "R9", "spu length", spu_q[0], 20 * C);
        check(!spu_en, "R9", "spu_en after done", spu_en, 0);
        spu_q.delete();

        // R9 zero hold time: no strong pullup
        for (int i = 0; i < 8; i++) ew_q.push_back(64 * C);
        push_exp(hold_rx, hold_pres, "R9");
        run_op(3'd3, 8'h00, 1'b1, 0, BYTE_LO, BYTE_HI, 0, "R9");
        check(spu_q.size() == 0, "R9", "spu pulse with zero time", spu_q.size(), 0);

        check(exp_q.size() == 0, "R10", "missing done", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule